// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Register Block

This block is the register window through which a host CPU controls a small embedded coprocessor and exchanges signals with it. The host reaches it over a simple 32-bit register bus with an address, a write enable, write data and combinational read data. Through this window the host can hold the coprocessor in reset or let it run, and choose how the local memory is split. It can post a message by ringing a doorbell, read the coprocessor program counter, arm a watchdog, and read and acknowledge the interrupt cause.

The coprocessor side drives three one-cycle strobes. One consumes the doorbell, one raises a message interrupt and one kicks the watchdog. The block drives a level interrupt to the host. That interrupt stays high while the cause register holds any bit. No new cause is delivered until the host acknowledges by writing zero. Causes that arrive in the meantime are kept pending and delivered one cycle after the acknowledge.

Top module: `cpx_mailbox_regs`

## Requirements
- R1: After reset every mapped register reads 0, `host_irq` is 0, `cp_run` is 0 and `mem_split` is 0.
- R2: The run control register at offset 0x00 stores bit 0, which drives `cp_run` (1 = running, 0 = held in reset). Its other bits read 0.
- R3: The memory split register at offset 0x08 stores `MEMCFG_W` (2) low bits, which drive `mem_split`. A value of 2 selects 96 KiB of program and 32 KiB of data memory. Its upper bits read 0.
- R4: A host write to the doorbell at offset 0x24 with bit 0 = 1 makes it read 1 from the next cycle. It reads 1 until a `cp_consume` strobe clears it to 0. A write with bit 0 = 0 has no effect.
- R5: A `cp_consume` strobe in the same cycle as a host doorbell write of 1 leaves the doorbell reading 1.
- R6: The interrupt cause register is at offset 0x1C. Bit 8 is the message cause and bit 0 is the watchdog cause. While the register is 0, a `cp_msg_raise` strobe sets bit 8 on the next cycle. `host_irq` is 1 exactly when the register is nonzero.
- R7: While the cause register is nonzero, new message or watchdog events leave it unchanged and are held pending. Once the host has cleared it, the register reads 0 for one cycle, and the pending causes appear in it on the following cycle.
- R8: A host write of exactly 0 to the cause register clears it. A write of any nonzero value is ignored.
- R9: The watchdog register is at offset 0x84. Bit 31 enables the watchdog and bits 15:0 hold the reload count N, both readable. Any write to the register loads the counter with N. While the watchdog is enabled and `cp_run` is 1, the counter decrements once per cycle. The cycle in which it reaches 0 sets cause bit 0, so with the core running, cause bit 0 is set N cycles after the write. A reload count of 0 never fires.
- R10: While the watchdog is disabled or the core is held in reset, the counter keeps its value and no watchdog cause is raised.
- R11: A `cp_wdt_kick` strobe reloads the counter with N, so expiry moves to N cycles after the kick.
- R12: The register at offset 0x60 reads the `cp_pc` input. Host writes to it have no effect.
- R13: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_addr | input | ADDR_W (8) | Host register byte address |
| bus_we | input | 1 | Host write enable, one write per cycle |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr |
| cp_consume | input | 1 | Coprocessor takes the doorbell message |
| cp_msg_raise | input | 1 | Coprocessor raises a message interrupt |
| cp_wdt_kick | input | 1 | Coprocessor reloads the watchdog |
| cp_pc | input | 32 | Coprocessor program counter |
| cp_run | output | 1 | 1 releases the coprocessor, 0 holds it in reset |
| mem_split | output | MEMCFG_W (2) | Program/data memory split selection |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The hardest state to reach from the ports is a cause that arrives while the cause register is already occupied. A watchdog expiry that lands behind a pending message is the hardest case of all. The stimulus first raises a message, then arms the watchdog with a short count so it expires while the message is unacknowledged. It then checks the single zero cycle and the late delivery after the acknowledge. A random phase drives message strobes and acknowledge or nonzero writes in arbitrary cycles against a reference model, which covers strobes that coincide with the clearing write. A similar random phase mixes doorbell posts and consumes, including posts and consumes in the same cycle.

// File: rtl/cpx_mbox_pkg.sv
package cpx_mbox_pkg;

   // Register byte offsets; host software depends on these positions
   localparam logic [31:0] OFS_RUN      = 32'h00;
   localparam logic [31:0] OFS_MEMCFG   = 32'h08;
   localparam logic [31:0] OFS_CAUSE    = 32'h1C;
   localparam logic [31:0] OFS_DOORBELL = 32'h24;
   localparam logic [31:0] OFS_PC       = 32'h60;
   localparam logic [31:0] OFS_WDT      = 32'h84;

   // Bit positions decoded by host software
   localparam int MSG_CAUSE_BIT = 8;
   localparam int WDT_CAUSE_BIT = 0;
   localparam int WDT_EN_BIT    = 31;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RUN,
      SEL_MEMCFG,
      SEL_CAUSE,
      SEL_DOORBELL,
      SEL_PC,
      SEL_WDT
   } reg_sel_e;

endpackage

// File: rtl/cpx_doorbell.sv
module cpx_doorbell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic consume_i,
   output logic busy_o
);

   logic busy_q;

   // A host post wins over a same-cycle consume
   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (set_i)
         busy_q <= 1'b1;
      else if (consume_i)
         busy_q <= 1'b0;
   end

   assign busy_o = busy_q;

   p_post_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> busy_o)
      else $error("doorbell lost a post");

   p_consume_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && consume_i && !set_i) |=> !busy_o)
      else $error("doorbell not cleared by consume");

   p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !consume_i) |=> $stable(busy_o))
      else $error("doorbell changed without cause");

endmodule

// File: rtl/cpx_watchdog.sv
module cpx_watchdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             run_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] reload_val_i,
   output logic             fire_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("watchdog counter needs at least 2 bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             active;

   assign active = en_i && run_i;
   assign fire_o = active && !reload_i && (cnt_q == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (reload_i)
         cnt_q <= reload_val_i;
      else if (active && (cnt_q != '0))
         cnt_q <= cnt_q - CNT_ONE;
   end

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !reload_i) |=> $stable(cnt_q))
      else $error("watchdog counted while idle");

   p_fire_reaches_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (cnt_q == '0))
      else $error("watchdog fired away from zero");

   p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (cnt_q == $past(reload_val_i)))
      else $error("watchdog reload lost");

endmodule

// File: rtl/cpx_irq_status.sv
module cpx_irq_status #(
   parameter int DW      = 32,
   parameter int MSG_BIT = 8,
   parameter int WDT_BIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          msg_raise_i,
   input  logic          wdt_fire_i,
   input  logic          clr_i,
   output logic [DW-1:0] cause_o,
   output logic          irq_o
);

   generate
      if (MSG_BIT == WDT_BIT || MSG_BIT >= DW || WDT_BIT >= DW) begin : g_bad_bits
         $error("cause bit positions must be distinct and inside the word");
      end
   endgenerate

   logic msg_q, wdt_q;
   logic msg_pend_q, wdt_pend_q;
   logic idle;

   assign idle = !msg_q && !wdt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_q      <= 1'b0;
         wdt_q      <= 1'b0;
         msg_pend_q <= 1'b0;
         wdt_pend_q <= 1'b0;
      end else if (idle) begin
         msg_q      <= msg_raise_i || msg_pend_q;
         wdt_q      <= wdt_fire_i  || wdt_pend_q;
         msg_pend_q <= 1'b0;
         wdt_pend_q <= 1'b0;
      end else begin
         msg_pend_q <= msg_pend_q || msg_raise_i;
         wdt_pend_q <= wdt_pend_q || wdt_fire_i;
         if (clr_i) begin
            msg_q <= 1'b0;
            wdt_q <= 1'b0;
         end
      end
   end

   always_comb begin
      cause_o          = '0;
      cause_o[MSG_BIT] = msg_q;
      cause_o[WDT_BIT] = wdt_q;
   end

   assign irq_o = msg_q || wdt_q;

   p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_o != '0) && !clr_i) |=> $stable(cause_o))
      else $error("cause changed while held off");

   p_pending_delivery_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_o == '0) && msg_pend_q) |=> cause_o[MSG_BIT])
      else $error("pending message not delivered");

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_o != '0) && clr_i) |=> (cause_o == '0))
      else $error("acknowledge did not clear causes");

   p_wdt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_o == '0) && wdt_fire_i) |=> cause_o[WDT_BIT])
      else $error("watchdog expiry not recorded");

endmodule

// File: rtl/cpx_mailbox_regs.sv
module cpx_mailbox_regs
   import cpx_mbox_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int MEMCFG_W = 2,
   parameter int WDT_W    = 16,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic                cp_consume,
   input  logic                cp_msg_raise,
   input  logic                cp_wdt_kick,
   input  logic [31:0]         cp_pc,
   output logic                cp_run,
   output logic [MEMCFG_W-1:0] mem_split,
   output logic                host_irq
);

   localparam int DW = 32;

   generate
      if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x84 and fit 31 bits");
      end
      if (WDT_W < 2 || WDT_W >= WDT_EN_BIT) begin : g_bad_wdt
         $error("WDT_W must leave the enable bit free");
      end
      if (MEMCFG_W < 2 || MEMCFG_W > 8) begin : g_bad_memcfg
         $error("MEMCFG_W must hold the value 2");
      end
   endgenerate

   logic [31:0]         addr_ext;
   reg_sel_e            sel;
   logic                run_q;
   logic [MEMCFG_W-1:0] memcfg_q;
   logic                wdt_en_q;
   logic [WDT_W-1:0]    wdt_reload_q;
   logic                db_set, db_busy;
   logic                cause_clr, wdt_wr, wdt_reload, wdt_fire;
   logic [DW-1:0]       cause;
   logic [31:0]         rd_c;

   assign addr_ext = 32'(bus_addr);

   always_comb begin
      case (addr_ext)
         OFS_RUN:      sel = SEL_RUN;
         OFS_MEMCFG:   sel = SEL_MEMCFG;
         OFS_CAUSE:    sel = SEL_CAUSE;
         OFS_DOORBELL: sel = SEL_DOORBELL;
         OFS_PC:       sel = SEL_PC;
         OFS_WDT:      sel = SEL_WDT;
         default:      sel = SEL_NONE;
      endcase
   end

   assign db_set     = bus_we && (sel == SEL_DOORBELL) && bus_wdata[0];
   assign cause_clr  = bus_we && (sel == SEL_CAUSE) && (bus_wdata == 32'h0);
   assign wdt_wr     = bus_we && (sel == SEL_WDT);
   assign wdt_reload = wdt_wr || cp_wdt_kick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q        <= 1'b0;
         memcfg_q     <= '0;
         wdt_en_q     <= 1'b0;
         wdt_reload_q <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_RUN:    run_q <= bus_wdata[0];
            SEL_MEMCFG: memcfg_q <= bus_wdata[MEMCFG_W-1:0];
            SEL_WDT: begin
               wdt_en_q     <= bus_wdata[WDT_EN_BIT];
               wdt_reload_q <= bus_wdata[WDT_W-1:0];
            end
            default: ;
         endcase
      end
   end

   cpx_doorbell u_doorbell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (db_set),
      .consume_i (cp_consume),
      .busy_o    (db_busy)
   );

   // The counter loads from the write data itself so a write and reload coincide
   cpx_watchdog #(.CNT_W(WDT_W)) u_watchdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (wdt_en_q),
      .run_i        (run_q),
      .reload_i     (wdt_reload),
      .reload_val_i (wdt_wr ? bus_wdata[WDT_W-1:0] : wdt_reload_q),
      .fire_o       (wdt_fire)
   );

   cpx_irq_status #(
      .DW      (DW),
      .MSG_BIT (MSG_CAUSE_BIT),
      .WDT_BIT (WDT_CAUSE_BIT)
   ) u_irq_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .msg_raise_i (cp_msg_raise),
      .wdt_fire_i  (wdt_fire),
      .clr_i       (cause_clr),
      .cause_o     (cause),
      .irq_o       (host_irq)
   );

   always_comb begin
      rd_c = '0;
      case (sel)
         SEL_RUN:      rd_c[0] = run_q;
         SEL_MEMCFG:   rd_c[MEMCFG_W-1:0] = memcfg_q;
         SEL_CAUSE:    rd_c = cause;
         SEL_DOORBELL: rd_c[0] = db_busy;
         SEL_PC:       rd_c = cp_pc;
         SEL_WDT: begin
            rd_c[WDT_EN_BIT]  = wdt_en_q;
            rd_c[WDT_W-1:0]   = wdt_reload_q;
         end
         default: rd_c = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rdata_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               rd_q <= '0;
            else
               rd_q <= rd_c;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rdata_comb
         assign bus_rdata = rd_c;
      end
   endgenerate

   assign cp_run    = run_q;
   assign mem_split = memcfg_q;

   p_run_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (sel == SEL_RUN)) |=> (cp_run == $past(bus_wdata[0])))
      else $error("run bit not written");

   p_split_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (sel == SEL_MEMCFG)) |=> $stable(mem_split))
      else $error("memory split changed without a write");

   p_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (sel == SEL_NONE)) |=> ($stable(cp_run) && $stable(mem_split)))
      else $error("unmapped write changed state");

endmodule

// File: tb/cpx_mailbox_regs_tb.sv
module cpx_mailbox_regs_tb_top;

   localparam logic [7:0] A_RUN   = 8'h00;
   localparam logic [7:0] A_MEM   = 8'h08;
   localparam logic [7:0] A_CAUSE = 8'h1C;
   localparam logic [7:0] A_DB    = 8'h24;
   localparam logic [7:0] A_PC    = 8'h60;
   localparam logic [7:0] A_WDT   = 8'h84;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        consume = 1'b0;
   logic        raise = 1'b0;
   logic        kick = 1'b0;
   logic [31:0] pc = '0;
   logic        cp_run;
   logic [1:0]  mem_split;
   logic        host_irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   cpx_mailbox_regs dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (addr),
      .bus_we       (we),
      .bus_wdata    (wdata),
      .bus_rdata    (rdata),
      .cp_consume   (consume),
      .cp_msg_raise (raise),
      .cp_wdt_kick  (kick),
      .cp_pc        (pc),
      .cp_run       (cp_run),
      .mem_split    (mem_split),
      .host_irq     (host_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic strobe_raise();
      @(negedge clk); raise = 1'b1;
      @(negedge clk); raise = 1'b0;
   endtask

   task automatic strobe_consume();
      @(negedge clk); consume = 1'b1;
      @(negedge clk); consume = 1'b0;
   endtask

   task automatic strobe_kick();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
   endtask

   function automatic logic db_next(input logic cur, input logic set, input logic cons);
      return set ? 1'b1 : (cons ? 1'b0 : cur);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic        m_db;
      logic [31:0] m_st;
      logic        m_pend;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_RUN, v);   chk("R1 run", v, 0);
      rd(A_MEM, v);   chk("R1 memcfg", v, 0);
      rd(A_CAUSE, v); chk("R1 cause", v, 0);
      rd(A_DB, v);    chk("R1 doorbell", v, 0);
      rd(A_WDT, v);   chk("R1 wdt", v, 0);
      chk("R1 irq", 32'(host_irq), 0);
      chk("R1 cp_run", 32'(cp_run), 0);
      chk("R1 mem_split", 32'(mem_split), 0);

      // R2 run control
      wr(A_RUN, 32'hFFFF_FFFF);
      rd(A_RUN, v); chk("R2 run read", v, 1);
      chk("R2 cp_run", 32'(cp_run), 1);
      wr(A_RUN, 32'h0);
      chk("R2 cp_run off", 32'(cp_run), 0);

      // R3 memory split
      wr(A_MEM, 32'h2);
      rd(A_MEM, v); chk("R3 split 2", v, 2);
      chk("R3 mem_split", 32'(mem_split), 2);
      wr(A_MEM, 32'hFFFF_FFFF);
      rd(A_MEM, v); chk("R3 upper bits", v, 3);
      wr(A_MEM, 32'h2);

      // R12 program counter readback
      pc = 32'hDEAD_0124;
      rd(A_PC, v); chk("R12 pc", v, 32'hDEAD_0124);
      wr(A_PC, 32'h0);
      rd(A_PC, v); chk("R12 pc write ignored", v, 32'hDEAD_0124);

      // R13 unmapped offsets
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h04, v); chk("R13 read 0x04", v, 0);
      rd(8'h40, v); chk("R13 read 0x40", v, 0);
      rd(A_RUN, v); chk("R13 run untouched", v, 0);
      rd(A_MEM, v); chk("R13 split untouched", v, 2);
      rd(A_DB, v);  chk("R13 doorbell untouched", v, 0);
      chk("R13 irq", 32'(host_irq), 0);

      // R4 doorbell post, ignored zero write, consume
      wr(A_DB, 32'h1);
      rd(A_DB, v); chk("R4 posted", v, 1);
      wr(A_DB, 32'h0);
      rd(A_DB, v); chk("R4 zero write ignored", v, 1);
      strobe_consume();
      rd(A_DB, v); chk("R4 consumed", v, 0);

      // R5 consume coinciding with a post
      @(negedge clk);
      addr = A_DB; we = 1'b1; wdata = 32'h1; consume = 1'b1;
      @(negedge clk);
      we = 1'b0; consume = 1'b0;
      rd(A_DB, v); chk("R5 post wins", v, 1);

      // R4 R5 random posts and consumes
      m_db = 1'b1;
      addr = A_DB;
      for (int i = 0; i < 300; i++) begin
         logic s_we, s_d, s_c;
         s_we = ($urandom % 2) == 0;
         s_d  = $urandom % 2;
         s_c  = ($urandom % 3) == 0;
         we = s_we; wdata = {31'h0, s_d}; consume = s_c;
         m_db = db_next(m_db, s_we && s_d, s_c);
         @(negedge clk);
         we = 1'b0; consume = 1'b0;
         #1;
         chk("R4/R5 random doorbell", 32'(rdata[0]), 32'(m_db));
      end
      strobe_consume();

      // R6 message cause and interrupt level
      strobe_raise();
      rd(A_CAUSE, v); chk("R6 msg cause", v, 32'h100);
      chk("R6 irq high", 32'(host_irq), 1);
      // R8 nonzero write ignored
      wr(A_CAUSE, 32'h5);
      rd(A_CAUSE, v); chk("R8 nonzero ignored", v, 32'h100);
      // R7 raise while busy is held pending
      strobe_raise();
      rd(A_CAUSE, v); chk("R7 held off", v, 32'h100);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, v); chk("R8 cleared", v, 0);
      chk("R7 irq low one cycle", 32'(host_irq), 0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R7 pending delivered", v, 32'h100);
      wr(A_CAUSE, 32'h0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R6 stays clear", v, 0);
      chk("R6 irq low", 32'(host_irq), 0);

      // R6 R7 R8 random raises and acknowledges
      m_st = 32'h0; m_pend = 1'b0;
      addr = A_CAUSE;
      for (int i = 0; i < 400; i++) begin
         logic s_r, s_w, s_z;
         s_r = ($urandom % 4) == 0;
         s_w = ($urandom % 3) == 0;
         s_z = ($urandom % 2) == 0;
         raise = s_r; we = s_w; wdata = s_z ? 32'h0 : 32'h1;
         if (m_st == 32'h0) begin
            m_st   = (m_pend || s_r) ? 32'h100 : 32'h0;
            m_pend = 1'b0;
         end else begin
            m_pend = m_pend || s_r;
            if (s_w && s_z) m_st = 32'h0;
         end
         @(negedge clk);
         raise = 1'b0; we = 1'b0;
         #1;
         chk("R7/R8 random cause", rdata, m_st);
         chk("R6 random irq", 32'(host_irq), 32'(m_st != 0));
      end
      // drain anything pending
      wr(A_CAUSE, 32'h0);
      @(negedge clk);
      wr(A_CAUSE, 32'h0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R8 drained", v, 0);

      // R10 idle while held in reset, then R9 expiry once running
      wr(A_WDT, 32'h8000_0003);
      rd(A_WDT, v); chk("R9 wdt readback", v, 32'h8000_0003);
      repeat (10) @(negedge clk);
      chk("R10 no expiry in reset", 32'(host_irq), 0);
      wr(A_RUN, 32'h1);
      repeat (2) @(negedge clk);
      chk("R10 count held then resumed", 32'(host_irq), 0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R9 expiry cause", v, 32'h1);
      wr(A_CAUSE, 32'h0);

      // R9 exact timing from a write
      wr(A_WDT, 32'h8000_0005);
      repeat (4) @(negedge clk);
      chk("R9 not yet expired", 32'(host_irq), 0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R9 expired after N", v, 32'h1);
      wr(A_CAUSE, 32'h0);

      // R11 kick moves the expiry
      wr(A_WDT, 32'h8000_0004);
      repeat (2) @(negedge clk);
      strobe_kick();
      repeat (3) @(negedge clk);
      chk("R11 kick delayed expiry", 32'(host_irq), 0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R11 expiry after kick", v, 32'h1);
      wr(A_CAUSE, 32'h0);

      // R10 disabled watchdog never fires
      wr(A_WDT, 32'h0000_0002);
      repeat (8) @(negedge clk);
      chk("R10 disabled", 32'(host_irq), 0);
      // R9 reload of zero never fires
      wr(A_WDT, 32'h8000_0000);
      repeat (8) @(negedge clk);
      chk("R9 zero reload", 32'(host_irq), 0);

      // R7 watchdog expiry behind an unacknowledged message
      wr(A_WDT, 32'h0);
      strobe_raise();
      wr(A_WDT, 32'h8000_0002);
      repeat (4) @(negedge clk);
      rd(A_CAUSE, v); chk("R7 wdt held behind msg", v, 32'h100);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, v); chk("R7 zero cycle", v, 0);
      @(negedge clk);
      rd(A_CAUSE, v); chk("R7 wdt delivered late", v, 32'h1);
      wr(A_WDT, 32'h0);
      wr(A_CAUSE, 32'h0);
      @(negedge clk);
      chk("R7 final clear", 32'(host_irq), 0);

      report();
      $finish;
   end

endmodule